// File: doc/BRIEF.md
# Bit-Serial Finite-Field Multiplier

This block multiplies two elements of the binary extension field GF(2^M). Each element is an M-bit vector of polynomial coefficients. Addition in the field is a bitwise XOR with no carries, and every product is reduced modulo a fixed irreducible polynomial, so the result is again M bits wide. The default field is M = 5, using the polynomial x^5 + x^2 + 1.

A one-cycle `start` pulse captures both operands. Operand `a` is held in parallel. Operand `b` is consumed one coefficient per clock, highest power first. An M-stage accumulator doubles its contents each cycle by shifting toward the higher powers, which multiplies it by x. The coefficient that leaves the top stage is folded back into stage 0 and into every stage whose polynomial coefficient is set. Where the current `b` coefficient is 1, `a` is then XORed in.

The reduction therefore lives in the shift-register feedback wiring, with no separate reduction stage. After M clocks the product appears on `p`, and `done` pulses for one cycle. The product stays on `p` until the next accepted start.

Top module: `gf_serial_mult`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it is released, `p` is all zeros and `done` is 0.
- R2: The result on `p` is the carry-less product of `a` and `b` reduced modulo x^M + Σ TAP_MASK[k]·x^k. Bit k of each vector is the coefficient of x^k. The default TAP_MASK is 5'b00101, which gives x^5+x^2+1; for example, 5'b00010 × 5'b10000 = 5'b00101.
- R3: A start accepted at clock edge n makes `done` high for exactly one cycle, following edge n+M−1, and low again after edge n+M.
- R4: Between `done` and the next accepted start, `p` holds the product unchanged.
- R5: A `start` pulse that arrives while a multiplication is in progress is ignored. The running product and its `done` timing are unaffected.
- R6: A start presented in the same cycle in which `done` is high is accepted, so operations can run back to back.
- R7: Multiplying by 5'b00001 returns `a` unchanged, and multiplying by zero returns zero.
- R8: For every `a`, the product `a`×`a` equals `a` with its bits moved to the even positions 2k of a 2M−1 bit vector, which is then reduced by the same polynomial.

Operand `b` is used highest coefficient first, so the first accumulation step depends only on `b[M-1]` (R2).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| start | input | 1 | Begin a multiplication; sampled at the clock edge |
| a | input | M | Multiplicand, captured on start |
| b | input | M | Multiplier, captured on start and consumed MSB first |
| p | output | M | Reduced product, valid while done is high and held afterwards |
| done | output | 1 | One-cycle pulse marking a valid product |

## Verification
Every one of the 1024 operand pairs for M = 5 is compared with a model that first forms the full carry-less product and then clears its high terms one at a time. A fault in any feedback tap, or in the order in which `b` is consumed, therefore shows up on some pair.

Squaring every element checks the result against the even-position spread form. This separates a correct diagonal from one where the cross terms fail to cancel.

Three directed patterns test specific paths:
- x times x^4 exercises exactly one reduction through the x^2 tap.
- Multiplication by one and by zero isolates the plain data path.
- A second start issued mid-run, and a start issued in the `done` cycle, exercise the sequencer's acceptance rule.

// File: rtl/gfm_pkg.sv
package gfm_pkg;

  // Width of a counter that must reach the value m.
  function automatic int cnt_bits(input int m);
    return (m < 2) ? 1 : $clog2(m + 1);
  endfunction

endpackage

// File: rtl/gfm_seq.sv
module gfm_seq #(
  parameter int M = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic load,
  output logic step_en,
  output logic busy,
  output logic done
);
  localparam int CW = gfm_pkg::cnt_bits(M);
  localparam logic [CW-1:0] LAST = CW'(M - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;
  logic          done_q, done_d;

  always_comb begin
    load    = start & ~busy_q;
    step_en = busy_q;
    cnt_d   = cnt_q;
    busy_d  = busy_q;
    done_d  = 1'b0;
    if (load) begin
      // the loading edge already performs the first step
      cnt_d = CW'(1);
      if (M == 1) done_d = 1'b1;
      else        busy_d = 1'b1;
    end else if (busy_q) begin
      cnt_d = cnt_q + CW'(1);
      if (cnt_q == LAST) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;
endmodule

// File: rtl/gfm_operand_reg.sv
module gfm_operand_reg #(
  parameter int M = 5
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         shift,
  input  logic [M-1:0] a_in,
  input  logic [M-1:0] b_in,
  output logic [M-1:0] a_q,
  output logic         b_msb
);
  logic [M-1:0] a_r, a_d;
  logic [M-1:0] b_r, b_d;
  logic         en;

  always_comb begin
    en  = load | shift;
    a_d = load ? a_in : a_r;
    // on load the top coefficient is consumed at once, so keep the rest
    b_d = load ? (b_in << 1) : (b_r << 1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_r <= '0;
      b_r <= '0;
    end else if (en) begin
      a_r <= a_d;
      b_r <= b_d;
    end
  end

  assign a_q   = a_r;
  assign b_msb = b_r[M-1];
endmodule

// File: rtl/gfm_accum.sv
module gfm_accum #(
  parameter int           M        = 5,
  parameter logic [M-1:0] TAP_MASK = 5'b00101
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         step_en,
  input  logic [M-1:0] a_op,
  input  logic         b_bit,
  output logic [M-1:0] acc
);
  logic [M-1:0] acc_q;
  logic [M-1:0] src;
  logic [M-1:0] nxt;
  logic         fold;
  logic         en;

  // a fresh operation starts from an empty accumulator
  assign src  = load ? '0 : acc_q;
  assign fold = src[M-1];
  assign en   = load | step_en;

  for (genvar k = 0; k < M; k++) begin : g_stage
    logic lower;
    logic partial;
    if (k == 0) begin : g_bottom
      assign lower = 1'b0;
    end else begin : g_upper
      assign lower = src[k-1];
    end
    assign partial = a_op[k] & b_bit;
    if (TAP_MASK[k]) begin : g_tap
      assign nxt[k] = lower ^ fold ^ partial;
    end else begin : g_plain
      assign nxt[k] = lower ^ partial;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else if (en) acc_q <= nxt;
  end

  assign acc = acc_q;
endmodule

// File: rtl/gf_serial_mult.sv
module gf_serial_mult #(
  parameter int           M        = 5,
  parameter logic [M-1:0] TAP_MASK = 5'b00101
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [M-1:0] a,
  input  logic [M-1:0] b,
  output logic [M-1:0] p,
  output logic         done
);
  logic         load;
  logic         step_en;
  logic         busy;
  logic [M-1:0] a_q;
  logic         b_msb;
  logic [M-1:0] a_op;
  logic         b_bit;

  gfm_seq #(.M(M)) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .load(load), .step_en(step_en), .busy(busy), .done(done)
  );

  gfm_operand_reg #(.M(M)) u_opr (
    .clk(clk), .rst_n(rst_n), .load(load), .shift(step_en),
    .a_in(a), .b_in(b), .a_q(a_q), .b_msb(b_msb)
  );

  // first step uses the live ports, later steps the captured operands
  assign a_op  = load ? a : a_q;
  assign b_bit = load ? b[M-1] : b_msb;

  gfm_accum #(.M(M), .TAP_MASK(TAP_MASK)) u_acc (
    .clk(clk), .rst_n(rst_n), .load(load), .step_en(step_en),
    .a_op(a_op), .b_bit(b_bit), .acc(p)
  );
endmodule

// File: rtl/gfm_chk.sv
module gfm_chk #(
  parameter int M = 5
) (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic [M-1:0] a,
  input logic [M-1:0] b,
  input logic [M-1:0] p,
  input logic         done,
  input logic         busy
);
  localparam int CW = gfm_pkg::cnt_bits(M) + 1;
  localparam logic [CW-1:0] FULL = CW'(M);

  logic [CW-1:0] ck;

  // counts clocks since the last accepted start
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               ck <= '0;
    else if (start && !busy)  ck <= CW'(1);
    else if (ck == FULL)      ck <= '0;
    else if (ck != '0)        ck <= ck + CW'(1);
  end

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3 R5
  done_timing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done == (ck == FULL));

  // R4
  p_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> $stable(p));

  // R2 R6
  first_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> p == ($past(a) & {M{$past(b[M-1])}}));
endmodule

bind gf_serial_mult gfm_chk #(.M(M)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .a(a), .b(b),
  .p(p), .done(done), .busy(busy)
);

// File: tb/gf_serial_mult_bench.sv
module gf_serial_mult_bench;
  localparam int           M    = 5;
  localparam logic [M-1:0] TAPS = 5'b00101;
  localparam int           W    = 2 * M - 1;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         start;
  logic [M-1:0] a, b;
  logic [M-1:0] p;
  logic         done;

  int total = 0;
  int bad   = 0;

  always #10 clk = ~clk;

  gf_serial_mult #(.M(M), .TAP_MASK(TAPS)) u_gf_serial_mult (
    .clk(clk), .rst_n(rst_n), .start(start), .a(a), .b(b),
    .p(p), .done(done)
  );

  function automatic logic [M-1:0] reduce(input logic [W-1:0] v);
    logic [W-1:0] r = v;
    logic [M:0]   poly = {1'b1, TAPS};
    for (int k = W - 1; k >= M; k--)
      if (r[k]) r = r ^ (W'(poly) << (k - M));
    return r[M-1:0];
  endfunction

  function automatic logic [M-1:0] ref_mul(input logic [M-1:0] x, input logic [M-1:0] y);
    logic [W-1:0] acc = '0;
    for (int i = 0; i < M; i++)
      if (y[i]) acc = acc ^ (W'(x) << i);
    return reduce(acc);
  endfunction

  function automatic logic [M-1:0] ref_sq(input logic [M-1:0] x);
    logic [W-1:0] s = '0;
    for (int i = 0; i < M; i++) s[2*i] = x[i];
    return reduce(s);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  // Runs one product; returns result and whether done timing and hold were right.
  task automatic do_mul(input logic [M-1:0] x, input logic [M-1:0] y,
                        output logic [M-1:0] r, output bit tim_ok);
    @(negedge clk);
    start = 1'b1; a = x; b = y;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    tim_ok = 1'b1;
    for (int i = 1; i < M; i++) begin
      if (done) tim_ok = 1'b0;
      @(posedge clk);
      @(negedge clk);
    end
    if (!done) tim_ok = 1'b0;
    r = p;
    @(posedge clk);
    @(negedge clk);
    if (done || p != r) tim_ok = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; start = 1'b0; a = '0; b = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(p == '0 && !done, "R1 reset state", {p, done}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(p == '0 && !done, "R1 after release", {p, done}, 0);
  endtask

  task automatic t_exhaustive();
    logic [M-1:0] r;
    bit tim;
    int nerr = 0;
    int terr = 0;
    for (int i = 0; i < (1 << M); i++)
      for (int j = 0; j < (1 << M); j++) begin
        do_mul(M'(i), M'(j), r, tim);
        if (r != ref_mul(M'(i), M'(j))) begin
          nerr++;
          check(1'b0, "R2 product", r, ref_mul(M'(i), M'(j)));
        end
        if (!tim) begin
          terr++;
          check(1'b0, "R3 R4 done/hold", i * 32 + j, 0);
        end
      end
    check(nerr == 0, "R2 all pairs", nerr, 0);
    check(terr == 0, "R3 R4 all pairs timing", terr, 0);
  endtask

  task automatic t_squares();
    logic [M-1:0] r;
    bit tim;
    int nerr = 0;
    for (int i = 0; i < (1 << M); i++) begin
      do_mul(M'(i), M'(i), r, tim);
      if (r != ref_sq(M'(i))) begin
        nerr++;
        check(1'b0, "R8 square", r, ref_sq(M'(i)));
      end
    end
    check(nerr == 0, "R8 all squares", nerr, 0);
  endtask

  task automatic t_directed();
    logic [M-1:0] r;
    bit tim;
    do_mul(5'b00010, 5'b10000, r, tim);
    check(r == 5'b00101, "R2 x*x^4", r, 5'b00101);
    check(tim, "R3 done pulse", tim, 1);
    do_mul(5'b10110, 5'b00001, r, tim);
    check(r == 5'b10110, "R7 times one", r, 5'b10110);
    do_mul(5'b11111, 5'b00000, r, tim);
    check(r == 5'b00000, "R7 times zero", r, 0);
  endtask

  task automatic t_busy_ignore();
    logic [M-1:0] exp = ref_mul(5'b10011, 5'b01101);
    bit tim = 1'b1;
    @(negedge clk);
    start = 1'b1; a = 5'b10011; b = 5'b01101;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    @(posedge clk);
    @(negedge clk);
    start = 1'b1; a = 5'b11111; b = 5'b11111;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0; a = '0; b = '0;
    for (int i = 3; i < M; i++) begin
      if (done) tim = 1'b0;
      @(posedge clk);
      @(negedge clk);
    end
    check(done && tim, "R5 done timing kept", done, 1);
    check(p == exp, "R5 product kept", p, exp);
    @(posedge clk);
    @(negedge clk);
    check(!done, "R5 no second done", done, 0);
  endtask

  task automatic t_back_to_back();
    logic [M-1:0] r;
    bit tim;
    logic [M-1:0] e2 = ref_mul(5'b01011, 5'b11010);
    do_mul(5'b00111, 5'b00101, r, tim);
    // rerun first op but issue the next start while done is high
    @(negedge clk);
    start = 1'b1; a = 5'b00111; b = 5'b00101;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    repeat (M - 1) begin
      @(posedge clk);
      @(negedge clk);
    end
    check(done, "R6 first done", done, 1);
    start = 1'b1; a = 5'b01011; b = 5'b11010;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    check(!done, "R6 done dropped", done, 0);
    repeat (M - 1) begin
      @(posedge clk);
      @(negedge clk);
    end
    check(done && p == e2, "R6 second product", p, e2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(1'b0, "watchdog expired", 0, 1);
    summary();
    $finish;
  end

  initial begin
    t_reset();
    t_directed();
    t_busy_ignore();
    t_back_to_back();
    t_squares();
    t_exhaustive();
    summary();
    $finish;
  end
endmodule